// File: doc/BRIEF.md
# Dual-Channel Converter Data Interleaver

This block is the digital front end that feeds the two 8-bit cores of a dual current-output converter. It delivers two registered codes, one per core, and both codes always change on the same rising edge of the conversion clock. In split mode each channel has its own input port. Both ports are sampled on a rising edge, and the sampled codes reach the outputs one rising edge later.

In interleaved mode only port A is used. It carries two words per clock period. The word present at a falling edge belongs to channel B. The word present at the next rising edge belongs to channel A. The pair is moved to both outputs together on the rising edge after that. Each channel therefore receives one code per clock period, which is half the word rate on the shared port.

Port A also carries control words. While the active-low write strobe is held low, the word on port A is not treated as sample data and the outputs keep their values. A change of mode throws away any channel-B word that has not yet been paired. The mode flag comes from the control-word decoder, which drives it low after power-up.

Top module: `dual_dac_ilv_front`

## Requirements
- R1: In the cycle after a reset edge, both output codes read 0x00.
- R2: With `ilv_en` = 0 and `wr_n` = 1 at a rising edge, `port_a` and `port_b` as sampled on that edge appear on `code_a` and `code_b` after the next rising edge.
- R3: With `ilv_en` = 1, the `port_a` word at a falling edge becomes channel B and the `port_a` word at the following rising edge becomes channel A. Both appear on `code_b` and `code_a` after the next rising edge.
- R4: `code_a` and `code_b` only ever update on the same rising edge. No edge loads a new code into one output while the other keeps a stale one.
- R5: While `ilv_en` = 1, the value on `port_b` has no effect on either output.
- R6: If `wr_n` is 0 at a rising edge, or at the falling edge just before it in interleaved mode, that edge captures no sample, and both outputs hold their values through the following rising edge.
- R7: On the first rising edge at which `ilv_en` reads 1 after reading 0, the half-captured channel-B word is discarded and the outputs do not change on the next edge. Output resumes with the first complete B/A pair.
- R8: Reset is synchronous and active high. It clears every capture stage, so no sample taken before reset can reach the outputs after it.
- R9: `ilv_en` = 1 selects interleaved mode. `ilv_en` = 0 selects split ports, which is the mode in force after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock; both edges are used in interleaved mode |
| rst | input | 1 | Synchronous active-high reset |
| ilv_en | input | 1 | 1 = interleaved on port A, 0 = separate ports |
| wr_n | input | 1 | Active-low control-word strobe; port A is not sample data while low |
| port_a | input | 8 | Channel A data, or both channels when interleaved |
| port_b | input | 8 | Channel B data in split mode |
| code_a | output | 8 | Registered code for converter core A |
| code_b | output | 8 | Registered code for converter core B |

## Verification
The properties assume that `ilv_en`, `wr_n` and `port_b` stay stable for a whole clock period between rising edges. They also assume that `port_a` is settled at each edge that samples it. The bench meets these assumptions by changing the controls and the channel-B word a quarter period after each rising edge, and the channel-A word a quarter period after each falling edge. The stimulus runs directed phases through mode switches, strobe-low windows and a mid-stream reset. It then runs a long random mix in which `port_b` keeps changing during interleaved stretches.

// File: rtl/dil_pkg.sv
package dil_pkg;

    localparam int CODE_W = 8;

    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic {
        MODE_SPLIT = 1'b0,
        MODE_ILV   = 1'b1
    } mode_e;

    typedef struct packed {
        code_t a;
        code_t b;
    } pair_t;

    typedef struct packed {
        logic  vld;
        pair_t pair;
    } slot_t;

    localparam code_t CODE_RST = '0;

    function automatic mode_e to_mode(input logic flag);
        return flag ? MODE_ILV : MODE_SPLIT;
    endfunction

endpackage

// File: rtl/dil_fall_capture.sv
// Falling-edge half of the interleaved path: latches the channel-B word.
module dil_fall_capture
    import dil_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  mode_e mode,
    input  logic  wr_n,
    input  code_t bus,
    output code_t b_word,
    output logic  b_vld
);

    logic take;
    assign take = (mode == MODE_ILV) && wr_n;

    always_ff @(negedge clk) begin
        if (rst) begin
            b_word <= CODE_RST;
            b_vld  <= 1'b0;
        end else begin
            b_vld <= take;
            if (take) begin
                b_word <= bus;
            end
        end
    end

endmodule

// File: rtl/dil_pair_select.sv
// Rising-edge capture: forms the sample pair for either mode.
module dil_pair_select
    import dil_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  mode_e mode,
    input  logic  wr_n,
    input  code_t bus_a,
    input  code_t bus_b,
    input  code_t b_word,
    input  logic  b_vld,
    output slot_t slot,
    output mode_e mode_q
);

    slot_t nxt;

    always_comb begin
        nxt.pair.a = bus_a;
        unique case (mode)
            MODE_SPLIT: begin
                nxt.pair.b = bus_b;
                nxt.vld    = wr_n;
            end
            MODE_ILV: begin
                // R5: port B plays no part here; R7: a fresh switch drops the half pair
                nxt.pair.b = b_word;
                nxt.vld    = wr_n && b_vld && (mode_q == MODE_ILV);
            end
            default: begin
                nxt.pair.b = bus_b;
                nxt.vld    = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot   <= '0;
            mode_q <= MODE_SPLIT;
        end else begin
            slot.vld <= nxt.vld;
            if (nxt.vld) begin
                slot.pair <= nxt.pair;
            end
            mode_q <= mode;
        end
    end

endmodule

// File: rtl/dil_out_stage.sv
// Output alignment: both codes load from one slot on one edge (R4).
module dil_out_stage
    import dil_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  slot_t slot,
    output pair_t held
);

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '{a: CODE_RST, b: CODE_RST};
        end else if (slot.vld) begin
            held <= slot.pair;
        end
    end

endmodule

// File: rtl/dual_dac_ilv_front.sv
module dual_dac_ilv_front
    import dil_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ilv_en,
    input  logic              wr_n,
    input  logic [CODE_W-1:0] port_a,
    input  logic [CODE_W-1:0] port_b,
    output logic [CODE_W-1:0] code_a,
    output logic [CODE_W-1:0] code_b
);

    mode_e mode;
    mode_e mode_q;
    code_t b_word;
    logic  b_vld;
    slot_t slot;
    pair_t held;

    // R9: flag value 1 selects interleaving
    assign mode = to_mode(ilv_en);

    dil_fall_capture u_fall (
        .clk    (clk),
        .rst    (rst),
        .mode   (mode),
        .wr_n   (wr_n),
        .bus    (port_a),
        .b_word (b_word),
        .b_vld  (b_vld)
    );

    dil_pair_select u_pair (
        .clk    (clk),
        .rst    (rst),
        .mode   (mode),
        .wr_n   (wr_n),
        .bus_a  (port_a),
        .bus_b  (port_b),
        .b_word (b_word),
        .b_vld  (b_vld),
        .slot   (slot),
        .mode_q (mode_q)
    );

    dil_out_stage u_out (
        .clk  (clk),
        .rst  (rst),
        .slot (slot),
        .held (held)
    );

    assign code_a = held.a;
    assign code_b = held.b;

endmodule

// File: rtl/dil_chk.sv
module dil_chk
    import dil_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  ilv_en,
    input logic  wr_n,
    input code_t port_a,
    input code_t port_b,
    input code_t code_a,
    input code_t code_b,
    input code_t b_word,
    input logic  b_vld,
    input logic  mode_ilv_q
);

    // R1 R8
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (code_a == CODE_RST && code_b == CODE_RST));

    // R2
    split_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (!ilv_en && wr_n && !rst) ##1 !rst
        |=> (code_a == $past(port_a, 2) && code_b == $past(port_b, 2)));

    // R3 R5
    ilv_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (ilv_en && wr_n && b_vld && mode_ilv_q && !rst) ##1 !rst
        |=> (code_a == $past(port_a, 2) && code_b == $past(b_word, 2)));

    // R6
    strobe_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_n && !rst) ##1 !rst
        |=> ($stable(code_a) && $stable(code_b)));

    // R7
    switch_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (ilv_en && !mode_ilv_q && !rst) ##1 !rst
        |=> ($stable(code_a) && $stable(code_b)));

endmodule

bind dual_dac_ilv_front dil_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ilv_en     (ilv_en),
    .wr_n       (wr_n),
    .port_a     (port_a),
    .port_b     (port_b),
    .code_a     (code_a),
    .code_b     (code_b),
    .b_word     (b_word),
    .b_vld      (b_vld),
    .mode_ilv_q (mode_q == dil_pkg::MODE_ILV)
);

// File: tb/tb_dual_dac_ilv_front.sv
module tb_dual_dac_ilv_front;
    timeunit 1ns;
    timeprecision 100ps;

    localparam real CLK_PERIOD = 10.0;
    localparam int  WATCHDOG_CYCLES = 50000;

    logic       clk = 1'b0;
    logic       rst, ilv_en, wr_n;
    logic [7:0] port_a, port_b;
    logic [7:0] code_a, code_b;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // reference model state
    logic [7:0] m_out_a = 8'h00, m_out_b = 8'h00;
    logic [7:0] m_cap_a = 8'h00, m_cap_b = 8'h00;
    bit         m_cap_v = 0;
    bit         m_prev_ilv = 0;

    dual_dac_ilv_front dut (
        .clk(clk), .rst(rst), .ilv_en(ilv_en), .wr_n(wr_n),
        .port_a(port_a), .port_b(port_b), .code_a(code_a), .code_b(code_b)
    );

    always #(CLK_PERIOD / 2.0) clk = ~clk;

    task automatic compare(input string tag);
        checks++;
        if (code_a !== m_out_a || code_b !== m_out_b) begin
            errors++;
            $display("FAIL %s actual a=%02h b=%02h expected a=%02h b=%02h at %0t",
                     tag, code_a, code_b, m_out_a, m_out_b, $time);
        end
    endtask

    // One clock period, entered a quarter period after a rising edge.
    task automatic step(input bit r, input bit ilv, input bit wn,
                        input logic [7:0] bword, input logic [7:0] aword,
                        input logic [7:0] pb, input string tag);
        bit bflag, v;
        rst = r; ilv_en = ilv; wr_n = wn; port_b = pb; port_a = bword;
        #(CLK_PERIOD / 2.0);
        port_a = aword;
        @(posedge clk);
        if (r) begin
            m_out_a = 8'h00; m_out_b = 8'h00;
            m_cap_a = 8'h00; m_cap_b = 8'h00;
            m_cap_v = 0; m_prev_ilv = 0;
        end else begin
            if (m_cap_v) begin
                m_out_a = m_cap_a; m_out_b = m_cap_b;
            end
            bflag = ilv && wn;
            v = ilv ? (wn && bflag && m_prev_ilv) : wn;
            if (v) begin
                m_cap_a = aword;
                m_cap_b = ilv ? bword : pb;
            end
            m_cap_v = v;
            m_prev_ilv = ilv;
        end
        #1;
        compare(tag);
        #(CLK_PERIOD / 4.0 - 1.0);
    endtask

    initial begin
        rst = 1; ilv_en = 0; wr_n = 1; port_a = 8'h00; port_b = 8'h00;
        #(CLK_PERIOD * 0.75);

        // R1 R8: reset state
        for (int i = 0; i < 3; i++) step(1, 0, 1, 8'h00, 8'hA5, 8'h5A, "R1");

        // R2 R9: split ports, one cycle latency
        step(0, 0, 1, 8'h00, 8'h11, 8'h22, "R2");
        step(0, 0, 1, 8'h00, 8'hFF, 8'h00, "R2");
        step(0, 0, 1, 8'h00, 8'h00, 8'hFF, "R2");
        step(0, 0, 1, 8'h00, 8'h80, 8'h7F, "R9");
        step(0, 0, 1, 8'h00, 8'h3C, 8'hC3, "R2");

        // R6: strobe low in split mode
        step(0, 0, 0, 8'h00, 8'hEE, 8'hDD, "R6");
        step(0, 0, 0, 8'h00, 8'h99, 8'h66, "R6");
        step(0, 0, 1, 8'h00, 8'h12, 8'h34, "R6");
        step(0, 0, 1, 8'h00, 8'h56, 8'h78, "R2");

        // R7: switch into interleaving drops the first half pair
        step(0, 1, 1, 8'hB1, 8'hA1, 8'h00, "R7");
        step(0, 1, 1, 8'hB2, 8'hA2, 8'h00, "R7");
        step(0, 1, 1, 8'hB3, 8'hA3, 8'h00, "R7");

        // R3 R5: interleaved pairs with port B toggling
        step(0, 1, 1, 8'h00, 8'hFF, 8'hC7, "R3");
        step(0, 1, 1, 8'hFF, 8'h00, 8'h1E, "R5");
        step(0, 1, 1, 8'h5A, 8'hA5, 8'hFF, "R5");
        step(0, 1, 1, 8'h01, 8'h02, 8'h44, "R3");

        // R6: strobe low in interleaved mode
        step(0, 1, 0, 8'hDE, 8'hAD, 8'h00, "R6");
        step(0, 1, 1, 8'h10, 8'h20, 8'h00, "R6");
        step(0, 1, 1, 8'h30, 8'h40, 8'h00, "R3");

        // R7 R9: back to split ports
        step(0, 0, 1, 8'hCC, 8'h61, 8'h62, "R7");
        step(0, 0, 1, 8'hCC, 8'h63, 8'h64, "R9");

        // R8: reset with data in flight
        step(0, 0, 1, 8'h00, 8'h77, 8'h88, "R8");
        step(1, 1, 1, 8'h99, 8'hAA, 8'hBB, "R8");
        step(0, 1, 1, 8'h9A, 8'hAB, 8'hBC, "R8");
        step(0, 1, 1, 8'h9B, 8'hAC, 8'hBD, "R8");

        // R4: random mix, both outputs checked together every cycle
        for (int i = 0; i < 400; i++) begin
            step((($urandom % 97) == 0), ($urandom % 4) != 0, ($urandom % 6) != 0,
                 8'($urandom), 8'($urandom), 8'($urandom), "R4");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG_CYCLES);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule